// File: doc/BRIEF.md
# PCI Interrupt Swizzle and Router

This block does two jobs for a host bridge that serves a set of PCI devices. The first job is a mapping query. A device/function number and an interrupt pin index go in, and out comes the index of one of four shared interrupt lines. A few board slots are wired to fixed lines. A group of four plug-in slots rotates its pins across the lines, so that the first pin of adjacent cards does not land on the same line. Every other slot keeps its pin index unchanged.

The second job is routing. Each of the four shared lines has a routing byte. The byte either names one of sixteen interrupt controller inputs or, at a value of sixteen or more, leaves the line disconnected. Each controller input is driven with the OR of the current levels of all lines routed to it. The block holds the controller request vector in a register. Storage of the routing bytes and the controller itself live outside the block.

Top module: `irq_swizzle_router`

## Requirements
- R1: The slot number is bits [7:3] of `qry_devfn`. The function bits [2:0] have no effect on `qry_line`.
- R2: Slot 10 maps every pin (0 to 3) to line 3.
- R3: Slots 11 and 12 map every pin to line 0.
- R4: Slots 18, 19, 20 and 21 map pin p to line ((slot - 18) + p) mod 4.
- R5: Every slot other than 10, 11, 12 and 18 to 21 maps pin p to line p.
- R6: Controller input k is high when at least one line whose routing byte equals k is at level 1. Line j's routing byte sits in bits [8j+7:8j] of `route_bytes`. Line j's level is bit j of `line_level`.
- R7: A line whose routing byte is 16 or more contributes to no controller input, whatever its level.
- R8: A controller input that no high line selects is driven 0.
- R9: `qry_line` follows its inputs combinationally. `ctrl_req` changes only at the first rising clock edge after a change of `line_level` or `route_bytes`.
- R10: While `rst_n` is low, `ctrl_req` is 0.
- R11: When two lines share a controller input and one of them falls, the input stays high for as long as the other line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| qry_devfn | input | 8 | Device/function number for the mapping query |
| qry_pin | input | 2 | Interrupt pin index, 0 to 3 |
| qry_line | output | 2 | Shared line that the queried pin maps to |
| line_level | input | 4 | Current level of each shared line |
| route_bytes | input | 32 | Four routing bytes, one per line, line 0 in the lowest byte |
| ctrl_req | output | 16 | Registered request levels to the interrupt controller |

## Verification
The mapping result has no register on its path, so the bench reads `qry_line` two nanoseconds after it drives the query at a falling edge. The request vector passes through one register. The bench therefore reads it twice for each new level and routing pattern. The first read comes just after the stimulus and must still show the previous vector. The second read comes at the next falling edge, after one rising edge, and must show the new vector. During reset the bench holds lines high and routed, and checks that the vector stays zero across several edges.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    localparam int DEVFN_W    = 8;
    localparam int FN_W       = 3;
    localparam int SLOT_W     = DEVFN_W - FN_W;
    localparam int PIN_W      = 2;
    localparam int NUM_LINES  = 4;
    localparam int LINE_W     = $clog2(NUM_LINES);
    localparam int ROUTE_W    = 8;
    localparam int NUM_INPUTS = 16;

    // Board slots with hard-wired line assignments
    localparam int FIXED_HI_SLOT   = 10;
    localparam int FIXED_HI_LINE   = 3;
    localparam int FIXED_LO_SLOT_A = 11;
    localparam int FIXED_LO_SLOT_B = 12;
    localparam int FIXED_LO_LINE   = 0;
    // Plug-in slots whose pins rotate across the lines
    localparam int ROT_FIRST_SLOT  = 18;
    localparam int ROT_LAST_SLOT   = 21;

    typedef struct packed {
        logic [NUM_INPUTS-1:0] req;
    } rtr_state_t;
endpackage

// File: rtl/pin_swizzle.sv
module pin_swizzle
    import irq_route_pkg::*;
#(
    parameter int S_W = SLOT_W,
    parameter int P_W = PIN_W,
    parameter int L_W = LINE_W
) (
    input  logic [S_W-1:0] slot_i,
    input  logic [P_W-1:0] pin_i,
    output logic [L_W-1:0] line_o
);
    logic [S_W-1:0] rot_ofs;

    always_comb begin
        rot_ofs = slot_i - S_W'(ROT_FIRST_SLOT);
        if (slot_i == S_W'(FIXED_HI_SLOT)) begin
            line_o = L_W'(FIXED_HI_LINE);
        end else if (slot_i == S_W'(FIXED_LO_SLOT_A) || slot_i == S_W'(FIXED_LO_SLOT_B)) begin
            line_o = L_W'(FIXED_LO_LINE);
        end else if (slot_i >= S_W'(ROT_FIRST_SLOT) && slot_i <= S_W'(ROT_LAST_SLOT)) begin
            line_o = rot_ofs[L_W-1:0] + L_W'(pin_i);
        end else begin
            line_o = L_W'(pin_i);
        end
    end
endmodule

// File: rtl/line_router.sv
module line_router
    import irq_route_pkg::*;
#(
    parameter int N_LINES = NUM_LINES,
    parameter int R_W     = ROUTE_W,
    parameter int N_IN    = NUM_INPUTS
) (
    input  logic [N_LINES-1:0]     level_i,
    input  logic [N_LINES*R_W-1:0] route_i,
    output logic [N_IN-1:0]        req_o
);
    localparam int IDX_W = $clog2(N_IN);

    logic [N_IN-1:0] line_hit [N_LINES];

    // One decoded target vector per line, gated by the line's level
    for (genvar j = 0; j < N_LINES; j++) begin : g_line
        logic [R_W-1:0] sel;
        logic           routed;
        assign sel    = route_i[j*R_W +: R_W];
        assign routed = (sel < R_W'(N_IN));
        assign line_hit[j] = (routed && level_i[j]) ? (N_IN'(1) << sel[IDX_W-1:0]) : '0;
    end

    always_comb begin
        req_o = '0;
        for (int j = 0; j < N_LINES; j++) begin
            req_o = req_o | line_hit[j];
        end
    end
endmodule

// File: rtl/irq_swizzle_router.sv
module irq_swizzle_router
    import irq_route_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [DEVFN_W-1:0]             qry_devfn,
    input  logic [PIN_W-1:0]               qry_pin,
    output logic [LINE_W-1:0]              qry_line,
    input  logic [NUM_LINES-1:0]           line_level,
    input  logic [NUM_LINES*ROUTE_W-1:0]   route_bytes,
    output logic [NUM_INPUTS-1:0]          ctrl_req
);
    rtr_state_t            st_d, st_q;
    logic [NUM_INPUTS-1:0] routed_req;
    logic [SLOT_W-1:0]     qry_slot;
    logic                  unused_fn;

    assign qry_slot  = qry_devfn[DEVFN_W-1:FN_W];
    assign unused_fn = ^qry_devfn[FN_W-1:0];

    pin_swizzle #(.S_W(SLOT_W), .P_W(PIN_W), .L_W(LINE_W)) u_swz (
        .slot_i (qry_slot),
        .pin_i  (qry_pin),
        .line_o (qry_line)
    );

    line_router #(.N_LINES(NUM_LINES), .R_W(ROUTE_W), .N_IN(NUM_INPUTS)) u_rtr (
        .level_i (line_level),
        .route_i (route_bytes),
        .req_o   (routed_req)
    );

    always_comb begin
        st_d     = st_q;
        st_d.req = routed_req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_req = st_q.req;

    // R2
    slot10_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qry_slot == SLOT_W'(FIXED_HI_SLOT)) |-> (qry_line == LINE_W'(FIXED_HI_LINE)));
    // R3
    slot11_12_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qry_slot == SLOT_W'(FIXED_LO_SLOT_A) || qry_slot == SLOT_W'(FIXED_LO_SLOT_B))
        |-> (qry_line == LINE_W'(FIXED_LO_LINE)));
    // R5
    low_slot_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qry_slot < SLOT_W'(FIXED_HI_SLOT)) |-> (qry_line == LINE_W'(qry_pin)));
    // R8
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(line_level) == '0) |-> (ctrl_req == '0));
    // R7
    unrouted_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(route_bytes[7:4] != 4'd0 && route_bytes[15:12] != 4'd0 &&
               route_bytes[23:20] != 4'd0 && route_bytes[31:28] != 4'd0))
        |-> (ctrl_req == '0));
    // R6
    fanin_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ctrl_req) <= $past($countones(line_level)));
endmodule

// File: tb/tb_irq_swizzle_router.sv
module tb_irq_swizzle_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  qry_devfn = '0;
    logic [1:0]  qry_pin = '0;
    logic [1:0]  qry_line;
    logic [3:0]  line_level = '0;
    logic [31:0] route_bytes = 32'h10101010;
    logic [15:0] ctrl_req;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    irq_swizzle_router dut (
        .clk(clk), .rst_n(rst_n), .qry_devfn(qry_devfn), .qry_pin(qry_pin),
        .qry_line(qry_line), .line_level(line_level),
        .route_bytes(route_bytes), .ctrl_req(ctrl_req)
    );

    // {devfn[63:56], pin[55:54], exp_line[53:52], level[51:48], routes[47:16], exp_req[15:0]}
    localparam int NV = 13;
    localparam logic [63:0] VEC [NV] = '{
        {8'h50, 2'd0, 2'd3, 4'b0001, 32'h10101009, 16'h0200}, // R2 R6
        {8'h57, 2'd2, 2'd3, 4'b0011, 32'h10100909, 16'h0200}, // R1 R2 R6
        {8'h5A, 2'd3, 2'd0, 4'b0010, 32'h10100909, 16'h0200}, // R3 R11
        {8'h60, 2'd1, 2'd0, 4'b0000, 32'h10100909, 16'h0000}, // R3 R8
        {8'h90, 2'd1, 2'd1, 4'b1111, 32'h0F0A0500, 16'h8421}, // R4 R6
        {8'h98, 2'd3, 2'd0, 4'b1010, 32'h0F0A0500, 16'h8020}, // R4 R8
        {8'hA0, 2'd3, 2'd1, 4'b1111, 32'hC803FF10, 16'h0008}, // R4 R7
        {8'hA8, 2'd1, 2'd0, 4'b1111, 32'h10101010, 16'h0000}, // R4 R7
        {8'h00, 2'd2, 2'd2, 4'b0101, 32'h07070707, 16'h0080}, // R5 R6
        {8'h88, 2'd3, 2'd3, 4'b1000, 32'h0E030201, 16'h4000}, // R5
        {8'hB0, 2'd1, 2'd1, 4'b0100, 32'h0E030201, 16'h0008}, // R5
        {8'hFF, 2'd0, 2'd0, 4'b0110, 32'h0E030201, 16'h000C}, // R1 R5
        {8'h48, 2'd2, 2'd2, 4'b1111, 32'h03020100, 16'h000F}  // R5 R6
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] prev_req;
        // R10: reset holds requests low even with routed high lines
        @(negedge clk);
        line_level  = 4'b1111;
        route_bytes = 32'h03020100;
        repeat (3) begin
            @(negedge clk);
            chk("R10 reset", 32'(ctrl_req), 32'h0);
        end
        rst_n = 1'b1;
        #2 chk("R9 before first edge", 32'(ctrl_req), 32'h0);
        @(negedge clk);
        chk("R6 first edge", 32'(ctrl_req), 32'h000F);
        line_level  = 4'b0000;
        route_bytes = 32'h10101010;
        @(negedge clk);
        prev_req = 16'h0000;
        chk("R8 cleared", 32'(ctrl_req), 32'h0);

        for (int i = 0; i < NV; i++) begin
            qry_devfn   = VEC[i][63:56];
            qry_pin     = VEC[i][55:54];
            line_level  = VEC[i][51:48];
            route_bytes = VEC[i][47:16];
            #2;
            chk($sformatf("R1-map vec%0d R2/R3/R4/R5", i), 32'(qry_line), 32'(VEC[i][53:52]));
            chk($sformatf("R9 hold vec%0d", i), 32'(ctrl_req), 32'(prev_req));
            @(negedge clk);
            chk($sformatf("R6/R7/R8 vec%0d", i), 32'(ctrl_req), 32'(VEC[i][15:0]));
            prev_req = VEC[i][15:0];
        end

        // R1: function bits ignored across all 8 values, slot 19 pin 2 -> line 3
        for (int f = 0; f < 8; f++) begin
            qry_devfn = 8'h98 | 8'(f);
            qry_pin   = 2'd2;
            #2 chk("R1 function bits", 32'(qry_line), 32'd3);
        end
        // R4: slot 21 over every pin
        for (int p = 0; p < 4; p++) begin
            qry_devfn = 8'hA8;
            qry_pin   = 2'(p);
            #2 chk("R4 slot21 sweep", 32'(qry_line), 32'((3 + p) % 4));
        end
        // R2: slot 10 over every pin
        for (int p = 0; p < 4; p++) begin
            qry_devfn = 8'h50;
            qry_pin   = 2'(p);
            #2 chk("R2 slot10 sweep", 32'(qry_line), 32'd3);
        end

        // R11: two lines share input 6, drop one then the other
        @(negedge clk);
        route_bytes = 32'h10100606;
        line_level  = 4'b0011;
        @(negedge clk);
        chk("R11 both high", 32'(ctrl_req), 32'h0040);
        line_level = 4'b0001;
        @(negedge clk);
        chk("R11 one left", 32'(ctrl_req), 32'h0040);
        line_level = 4'b0000;
        @(negedge clk);
        chk("R11 none left", 32'(ctrl_req), 32'h0000);

        // R7: route value exactly 16 versus 15
        route_bytes = 32'h1010100F;
        line_level  = 4'b0001;
        @(negedge clk);
        chk("R7 route 15", 32'(ctrl_req), 32'h8000);
        route_bytes = 32'h10101010;
        #2 chk("R9 route change hold", 32'(ctrl_req), 32'h8000);
        @(negedge clk);
        chk("R7 route 16", 32'(ctrl_req), 32'h0000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule